// File: doc/BRIEF.md
# Local/Global Memory Access Unit

This unit sits between a hardware thread's user logic and the memory it can reach. The user logic places an operation code, a word address and, for stores, a data word on its request pins while the unit shows GO. The unit accepts the request on that clock edge and shows WAIT until the operation is done. Completed loads leave their data in a value register.

Each accepted address is compared against a private window of on-chip RAM. A hit is served from the user port of a dual-port RAM. A miss becomes one single-beat read or write on a simple request/acknowledge bus master port. The RAM's second port is exposed as a plain slave port, so other cores can read and write the same words. A local access never touches the bus master port, so it proceeds whatever other traffic the system carries.

Controller states:
- `ST_IDLE` shows GO and samples the request.
- `ST_LWR` performs the local write.
- `ST_LRD_ISSUE`, `ST_LRD_HOLD` and `ST_LRD_TAKE` issue, hold and capture a local read.
- `ST_BUS` waits for the bus acknowledge.

Transitions:
- `ST_IDLE` goes to `ST_LWR` on a local store, to `ST_LRD_ISSUE` on a local load, and to `ST_BUS` on any miss.
- `ST_LWR` returns to `ST_IDLE`.
- `ST_LRD_ISSUE` goes to `ST_LRD_HOLD`, then to `ST_LRD_TAKE`, then back to `ST_IDLE`.
- `ST_BUS` stays until the acknowledge arrives, then returns to `ST_IDLE`.

Top module: `mem_access_unit`

## Requirements
- R1: After reset `usr_go` is 1 (GO), `bm_req` is 0 and `usr_value` is 0.
- R2: A LOAD (`usr_op`=2'b01) or STORE (`usr_op`=2'b10) seen on a rising edge while `usr_go` is 1 is accepted, and `usr_go` is 0 (WAIT) in the following cycle.
- R3: A local STORE keeps `usr_go` at 0 for exactly 1 cycle, and the word then holds the stored data.
- R4: A local LOAD keeps `usr_go` at 0 for exactly 3 cycles; when `usr_go` returns to 1, `usr_value` holds the addressed word.
- R5: An address is local exactly when its bits above the low LW bits equal those of LOCAL_BASE. The low LW bits select the RAM word. The first and last words of the window are local, and the words just outside it are not.
- R6: A miss raises `bm_req` with `bm_we` (1 for store), `bm_addr` and `bm_wdata` held stable until `bm_ack`. `usr_go` stays 0 until the edge that sees `bm_ack`, after which `bm_req` is 0 and `usr_go` is 1. A load then holds `bm_rdata` in `usr_value`.
- R7: A local access never raises `bm_req`.
- R8: An operation code offered while `usr_go` is 0 is ignored. NOP (2'b00) and the reserved code 2'b11 are ignored even while `usr_go` is 1.
- R9: The slave port writes the word at `sl_addr` when `sl_en` and `sl_we` are 1. A slave read returns the word on `sl_rdata` one cycle after `sl_en`. Slave accesses work in the same cycles as user-side local accesses.
- R10: When the slave port and the user port hit the same word in the same cycle and at least one of them writes, `lm_collide` is 1 in that cycle. If both write, the user port's data is the data kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_op | input | 2 | Operation code: 00 NOP, 01 LOAD, 10 STORE, 11 reserved |
| usr_addr | input | AW | Word address of the request |
| usr_wdata | input | DW | Store data |
| usr_go | output | 1 | 1 = GO (request accepted), 0 = WAIT |
| usr_value | output | DW | Value register, holds the result of the last load |
| bm_req | output | 1 | Bus master request |
| bm_we | output | 1 | Bus master write enable |
| bm_addr | output | AW | Bus master address |
| bm_wdata | output | DW | Bus master write data |
| bm_ack | input | 1 | Bus acknowledge, one cycle |
| bm_rdata | input | DW | Bus read data, valid with `bm_ack` |
| sl_en | input | 1 | Slave port access enable |
| sl_we | input | 1 | Slave port write enable |
| sl_addr | input | LW | Slave port word index into local RAM |
| sl_wdata | input | DW | Slave port write data |
| sl_rdata | output | DW | Slave port read data, one cycle after `sl_en` |
| lm_collide | output | 1 | Same-word conflict between the two RAM ports this cycle |

## Verification
The bench builds the unit with a 16-bit address, 32-bit data, LW=4 (a 16-word window) and LOCAL_BASE=16'h0130.

The small window puts the words 0x012F and 0x0140, which sit right at the window's edges, within a few directed accesses. It also keeps the address range narrow enough to pick colliding slave and user words by hand.

The bench's bus responder has a run-time wait-state count, set to 0, 2 and 4. This shows the WAIT length following the acknowledge, and it leaves room to offer stray opcodes while a miss is still outstanding.

// File: rtl/mau_pkg.sv
package mau_pkg;

    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_RSVD  = 2'b11
    } mau_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LWR,
        ST_LRD_ISSUE,
        ST_LRD_HOLD,
        ST_LRD_TAKE,
        ST_BUS
    } mau_state_e;

endpackage

// File: rtl/mau_win_decode.sv
module mau_win_decode #(
    parameter int          AW         = 32,
    parameter int          LW         = 8,
    parameter logic [AW-1:0] LOCAL_BASE = '0
) (
    input  logic [AW-1:0] addr,
    output logic          is_local,
    output logic [LW-1:0] offset
);
    localparam int TAG_W = AW - LW;
    localparam logic [TAG_W-1:0] BASE_TAG = LOCAL_BASE[AW-1:LW];

    always_comb begin
        is_local = (addr[AW-1:LW] == BASE_TAG);
        offset   = addr[LW-1:0];
    end

    initial begin
        assert (LOCAL_BASE[LW-1:0] == '0)
            else $error("assert_base_aligned_R5: window base not aligned");
    end
endmodule

// File: rtl/mau_dpram.sv
module mau_dpram #(
    parameter int DW = 32,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [LW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [LW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          collide
);
    localparam int DEPTH = 1 << LW;

    logic [DW-1:0] mem [DEPTH];
    logic          same_word;
    logic          a_wr, b_wr;

    always_comb begin
        same_word = a_en && b_en && (a_addr == b_addr);
        collide   = same_word && (a_we || b_we);
        a_wr      = a_en && a_we;
        b_wr      = b_en && b_we && !(same_word && a_we);
    end

    always_ff @(posedge clk) begin
        if (a_wr) mem[a_addr] <= a_wdata;
        if (b_wr) mem[b_addr] <= b_wdata;
        if (a_en && !a_we) a_rdata <= mem[a_addr];
        if (b_en && !b_we) b_rdata <= mem[b_addr];
    end

    // R10: on a double write to one word the user port's data survives
    assert_collision_user_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we && b_en && b_we && a_addr == b_addr)
        |=> mem[$past(a_addr)] == $past(a_wdata));
endmodule

// File: rtl/mau_ctrl.sv
module mau_ctrl
    import mau_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          is_local,
    input  logic [LW-1:0] offset,
    output logic          ready,
    output logic [DW-1:0] value,
    output logic          ram_en,
    output logic          ram_we,
    output logic [LW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata,
    output logic          local_busy,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    input  logic          m_ack,
    input  logic [DW-1:0] m_rdata
);
    mau_state_e    state, state_nx;
    mau_op_e       op_e;
    logic          accept;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_data;
    logic [LW-1:0] lat_off;
    logic          lat_we;

    always_comb begin
        op_e   = mau_op_e'(op);
        accept = (state == ST_IDLE) && (op_e == OP_LOAD || op_e == OP_STORE);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (!is_local)              state_nx = ST_BUS;
                    else if (op_e == OP_STORE)  state_nx = ST_LWR;
                    else                        state_nx = ST_LRD_ISSUE;
                end
            end
            ST_LWR:       state_nx = ST_IDLE;
            ST_LRD_ISSUE: state_nx = ST_LRD_HOLD;
            ST_LRD_HOLD:  state_nx = ST_LRD_TAKE;
            ST_LRD_TAKE:  state_nx = ST_IDLE;
            ST_BUS:       if (m_ack) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready      = 1'b0;
        ram_en     = 1'b0;
        ram_we     = 1'b0;
        m_req      = 1'b0;
        local_busy = 1'b0;
        unique case (state)
            ST_IDLE:      ready = 1'b1;
            ST_LWR:       begin ram_en = 1'b1; ram_we = 1'b1; local_busy = 1'b1; end
            ST_LRD_ISSUE: begin ram_en = 1'b1; local_busy = 1'b1; end
            ST_LRD_HOLD:  local_busy = 1'b1;
            ST_LRD_TAKE:  local_busy = 1'b1;
            ST_BUS:       m_req = 1'b1;
            default:      ready = 1'b0;
        endcase
        ram_addr  = lat_off;
        ram_wdata = lat_data;
        m_we      = lat_we;
        m_addr    = lat_addr;
        m_wdata   = lat_data;
    end

    // request latch and value register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_data <= '0;
            lat_off  <= '0;
            lat_we   <= 1'b0;
            value    <= '0;
        end else begin
            if (accept) begin
                lat_addr <= addr;
                lat_data <= wdata;
                lat_off  <= offset;
                lat_we   <= (op_e == OP_STORE);
            end
            if (state == ST_LRD_TAKE)
                value <= ram_rdata;
            else if (state == ST_BUS && m_ack && !lat_we)
                value <= m_rdata;
        end
    end

    assert_wait_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && (op == 2'b01 || op == 2'b10)) |=> !ready);

    assert_write_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && ram_we) |=> ready);

    assert_read_pipeline_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !ram_we) |=> (!ready && !ram_en));

    assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

    assert_req_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ack) |=> (!m_req && ready));

    assert_idle_ops_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && (op == 2'b00 || op == 2'b11)) |=> ready);
endmodule

// File: rtl/mem_access_unit.sv
module mem_access_unit #(
    parameter int            AW         = 32,
    parameter int            DW         = 32,
    parameter int            LW         = 8,
    parameter logic [AW-1:0] LOCAL_BASE = 32'h0001_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    usr_op,
    input  logic [AW-1:0] usr_addr,
    input  logic [DW-1:0] usr_wdata,
    output logic          usr_go,
    output logic [DW-1:0] usr_value,
    output logic          bm_req,
    output logic          bm_we,
    output logic [AW-1:0] bm_addr,
    output logic [DW-1:0] bm_wdata,
    input  logic          bm_ack,
    input  logic [DW-1:0] bm_rdata,
    input  logic          sl_en,
    input  logic          sl_we,
    input  logic [LW-1:0] sl_addr,
    input  logic [DW-1:0] sl_wdata,
    output logic [DW-1:0] sl_rdata,
    output logic          lm_collide
);
    logic          hit;
    logic [LW-1:0] hit_off;
    logic          ram_en, ram_we, local_busy;
    logic [LW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata, ram_rdata;

    mau_win_decode #(.AW(AW), .LW(LW), .LOCAL_BASE(LOCAL_BASE)) u_dec (
        .addr     (usr_addr),
        .is_local (hit),
        .offset   (hit_off)
    );

    mau_ctrl #(.AW(AW), .DW(DW), .LW(LW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (usr_op),
        .addr       (usr_addr),
        .wdata      (usr_wdata),
        .is_local   (hit),
        .offset     (hit_off),
        .ready      (usr_go),
        .value      (usr_value),
        .ram_en     (ram_en),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_rdata  (ram_rdata),
        .local_busy (local_busy),
        .m_req      (bm_req),
        .m_we       (bm_we),
        .m_addr     (bm_addr),
        .m_wdata    (bm_wdata),
        .m_ack      (bm_ack),
        .m_rdata    (bm_rdata)
    );

    mau_dpram #(.DW(DW), .LW(LW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_en    (ram_en),
        .a_we    (ram_we),
        .a_addr  (ram_addr),
        .a_wdata (ram_wdata),
        .a_rdata (ram_rdata),
        .b_en    (sl_en),
        .b_we    (sl_we),
        .b_addr  (sl_addr),
        .b_wdata (sl_wdata),
        .b_rdata (sl_rdata),
        .collide (lm_collide)
    );

    // R7: the RAM-side pipeline and the bus master never run together
    assert_local_no_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        local_busy |-> !bm_req);
endmodule

// File: tb/test_mem_access_unit.sv
module test_mem_access_unit;
    localparam int            AW   = 16;
    localparam int            DW   = 32;
    localparam int            LW   = 4;
    localparam logic [AW-1:0] BASE = 16'h0130;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    usr_op = 2'b00;
    logic [AW-1:0] usr_addr = '0;
    logic [DW-1:0] usr_wdata = '0;
    logic          usr_go;
    logic [DW-1:0] usr_value;
    logic          bm_req, bm_we;
    logic [AW-1:0] bm_addr;
    logic [DW-1:0] bm_wdata;
    logic          bm_ack = 1'b0;
    logic [DW-1:0] bm_rdata = '0;
    logic          sl_en = 1'b0, sl_we = 1'b0;
    logic [LW-1:0] sl_addr = '0;
    logic [DW-1:0] sl_wdata = '0;
    logic [DW-1:0] sl_rdata;
    logic          lm_collide;

    int n_chk = 0, n_bad = 0;
    int bus_ws = 0, ws_cnt = 0;
    int ack_count = 0, req_cycles = 0;
    logic [AW-1:0] last_wr_addr = '0;
    logic [DW-1:0] last_wr_data = '0;
    logic          last_we = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    mem_access_unit #(.AW(AW), .DW(DW), .LW(LW), .LOCAL_BASE(BASE)) i_mem_access_unit (
        .clk(clk), .rst_n(rst_n), .usr_op(usr_op), .usr_addr(usr_addr),
        .usr_wdata(usr_wdata), .usr_go(usr_go), .usr_value(usr_value),
        .bm_req(bm_req), .bm_we(bm_we), .bm_addr(bm_addr), .bm_wdata(bm_wdata),
        .bm_ack(bm_ack), .bm_rdata(bm_rdata), .sl_en(sl_en), .sl_we(sl_we),
        .sl_addr(sl_addr), .sl_wdata(sl_wdata), .sl_rdata(sl_rdata),
        .lm_collide(lm_collide)
    );

    function automatic logic [DW-1:0] bus_word(input logic [AW-1:0] a);
        return {16'hB0B0, a};
    endfunction

    // bus responder: ack after bus_ws wait states
    always @(negedge clk) begin
        if (!rst_n) begin
            bm_ack = 1'b0;
            ws_cnt = 0;
        end else if (bm_ack) begin
            bm_ack = 1'b0;
        end else if (bm_req) begin
            if (ws_cnt >= bus_ws) begin
                bm_ack   = 1'b1;
                bm_rdata = bus_word(bm_addr);
                last_we  = bm_we;
                if (bm_we) begin
                    last_wr_addr = bm_addr;
                    last_wr_data = bm_wdata;
                end
                ack_count++;
                ws_cnt = 0;
            end else begin
                ws_cnt++;
            end
        end
    end

    always @(posedge clk) if (bm_req) req_cycles++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue one op at a negedge with GO, return cycles spent in WAIT
    task automatic do_op(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output int busy);
        busy = 0;
        while (!usr_go) @(negedge clk);
        usr_op = op; usr_addr = a; usr_wdata = d;
        @(posedge clk);
        @(negedge clk);
        usr_op = 2'b00;
        while (!usr_go && busy < 100) begin
            busy++;
            @(negedge clk);
        end
    endtask

    task automatic sl_read(input logic [LW-1:0] idx, output logic [DW-1:0] d);
        @(negedge clk);
        sl_en = 1'b1; sl_we = 1'b0; sl_addr = idx;
        @(posedge clk);
        @(negedge clk);
        sl_en = 1'b0;
        d = sl_rdata;
    endtask

    task automatic sl_write(input logic [LW-1:0] idx, input logic [DW-1:0] d);
        @(negedge clk);
        sl_en = 1'b1; sl_we = 1'b1; sl_addr = idx; sl_wdata = d;
        @(posedge clk);
        @(negedge clk);
        sl_en = 1'b0; sl_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 go after reset", {31'd0, usr_go}, 32'd1);
        chk("R1 bm_req after reset", {31'd0, bm_req}, 32'd0);
        chk("R1 value after reset", usr_value, 32'd0);
    endtask

    task automatic t_local();
        int b, acks, reqs;
        logic [DW-1:0] d;
        acks = ack_count; reqs = req_cycles;
        // R2: WAIT on the cycle after acceptance
        @(negedge clk);
        usr_op = 2'b10; usr_addr = 16'h0133; usr_wdata = 32'hDEAD_BEEF;
        @(posedge clk); @(negedge clk);
        chk("R2 wait after accept", {31'd0, usr_go}, 32'd0);
        usr_op = 2'b00;
        @(negedge clk);
        chk("R3 store back to GO after 1 cycle", {31'd0, usr_go}, 32'd1);
        sl_read(4'd3, d);
        chk("R3 stored word via slave port", d, 32'hDEAD_BEEF);
        do_op(2'b01, 16'h0133, '0, b);
        chk("R4 load wait cycles", b, 3);
        chk("R4 load value", usr_value, 32'hDEAD_BEEF);
        // R5 window edges
        do_op(2'b10, 16'h0130, 32'h1111_0000, b);
        chk("R5 first word local store", b, 1);
        do_op(2'b10, 16'h013F, 32'h2222_000F, b);
        chk("R5 last word local store", b, 1);
        do_op(2'b01, 16'h0130, '0, b);
        chk("R5 first word load", usr_value, 32'h1111_0000);
        do_op(2'b01, 16'h013F, '0, b);
        chk("R5 last word load", usr_value, 32'h2222_000F);
        sl_read(4'hF, d);
        chk("R5 last word maps to index 15", d, 32'h2222_000F);
        chk("R7 no bus ack during local ops", ack_count, acks);
        chk("R7 no bm_req during local ops", req_cycles, reqs);
    endtask

    task automatic t_bus();
        int b, acks;
        logic [DW-1:0] d;
        acks = ack_count;
        bus_ws = 0;
        do_op(2'b01, 16'h012F, '0, b);
        chk("R6 miss below window wait", b, 1);
        chk("R6 miss load value", usr_value, bus_word(16'h012F));
        chk("R5 0x012F is a miss", ack_count, acks + 1);
        bus_ws = 4;
        do_op(2'b10, 16'h0140, 32'hCAFE_0140, b);
        chk("R6 store wait follows ack", b, 5);
        chk("R6 store bm_we", {31'd0, last_we}, 32'd1);
        chk("R6 store bm_addr", {16'd0, last_wr_addr}, 32'h0000_0140);
        chk("R6 store bm_wdata", last_wr_data, 32'hCAFE_0140);
        chk("R5 0x0140 is a miss", ack_count, acks + 2);
        chk("R6 req released", {31'd0, bm_req}, 32'd0);
        sl_read(4'd0, d);
        chk("R5 miss leaves local word 0", d, 32'h1111_0000);
        bus_ws = 2;
        do_op(2'b01, 16'h2000, '0, b);
        chk("R6 far load wait", b, 3);
        chk("R6 far load value", usr_value, bus_word(16'h2000));
    endtask

    task automatic t_ignore();
        int acks;
        logic [DW-1:0] d;
        bus_ws = 4;
        acks = ack_count;
        while (!usr_go) @(negedge clk);
        usr_op = 2'b01; usr_addr = 16'h2004;
        @(posedge clk); @(negedge clk);
        // stray STORE to a local word while WAIT
        usr_op = 2'b10; usr_addr = 16'h0133; usr_wdata = 32'hBAD0_BAD0;
        @(negedge clk); @(negedge clk);
        usr_op = 2'b00;
        while (!usr_go) @(negedge clk);
        chk("R8 one bus op only", ack_count, acks + 1);
        chk("R8 original load result", usr_value, bus_word(16'h2004));
        sl_read(4'd3, d);
        chk("R8 stray store ignored", d, 32'hDEAD_BEEF);
        // reserved code while GO
        usr_op = 2'b11; usr_addr = 16'h2008;
        @(posedge clk); @(negedge clk);
        chk("R8 reserved code keeps GO", {31'd0, usr_go}, 32'd1);
        usr_op = 2'b00; usr_addr = 16'h0133;
        @(posedge clk); @(negedge clk);
        chk("R8 NOP keeps GO", {31'd0, usr_go}, 32'd1);
        chk("R8 reserved code no bus", ack_count, acks + 1);
    endtask

    task automatic t_slave();
        logic [DW-1:0] d;
        sl_write(4'd5, 32'h5555_AAAA);
        // user local load overlapping slave writes to other words
        while (!usr_go) @(negedge clk);
        usr_op = 2'b01; usr_addr = 16'h0135;
        @(posedge clk); @(negedge clk);
        usr_op = 2'b00;
        for (int i = 0; i < 3; i++) begin
            sl_en = 1'b1; sl_we = 1'b1; sl_addr = LW'(8 + i); sl_wdata = 32'h8800_0000 + i;
            @(posedge clk); @(negedge clk);
        end
        sl_en = 1'b0; sl_we = 1'b0;
        chk("R9 user load beside slave writes", usr_value, 32'h5555_AAAA);
        chk("R9 go after overlapped load", {31'd0, usr_go}, 32'd1);
        sl_read(4'd9, d);
        chk("R9 slave write landed", d, 32'h8800_0001);
        sl_read(4'd10, d);
        chk("R9 slave write landed last", d, 32'h8800_0002);
    endtask

    task automatic t_collide();
        logic [DW-1:0] d;
        while (!usr_go) @(negedge clk);
        chk("R10 no collide when idle", {31'd0, lm_collide}, 32'd0);
        usr_op = 2'b10; usr_addr = 16'h0136; usr_wdata = 32'hAAAA_0006;
        @(posedge clk); @(negedge clk);
        usr_op = 2'b00;
        sl_en = 1'b1; sl_we = 1'b1; sl_addr = 4'd6; sl_wdata = 32'hBBBB_0006;
        #1;
        chk("R10 collide flagged", {31'd0, lm_collide}, 32'd1);
        @(posedge clk); @(negedge clk);
        sl_en = 1'b0; sl_we = 1'b0;
        #1;
        chk("R10 collide clears", {31'd0, lm_collide}, 32'd0);
        sl_read(4'd6, d);
        chk("R10 user write wins", d, 32'hAAAA_0006);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_local();
        t_bus();
        t_ignore();
        t_slave();
        t_collide();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule